// File: doc/BRIEF.md
# DES Last-Round Selection-Bit Predictor

This block supports a power-analysis experiment on a DES engine. A host hands it one 64-bit ciphertext and picks one of the eight S-boxes. The block then works out a one-bit prediction for each of the 64 possible 6-bit round-key chunks of that S-box. It does this by running part of the final DES round backwards from the ciphertext. Each prediction says whether the chosen S-box output bit, once it has been moved by the P permutation, differs from the matching bit of the left half. The caller sorts the recorded traces by these bits. The candidate whose sorting gives the largest average difference is taken as the correct subkey chunk. Running all eight S-boxes covers 48 key bits.

The part of the work that does not depend on the guess is done once, in the cycle that accepts the start pulse. That part is the initial permutation, the expansion of R, the pick of six bits and the pick of the matching L bit. The block then steps through the guesses one per clock, from 0 to 63, and writes bit i of the result vector for guess i. When the last guess is done it raises a one-cycle ready pulse. It holds the vector until the next accepted start. The S-box output bit under test is a build parameter, and its default is the most significant bit.

Top module: `des_sel_predictor`

## Requirements
- R1: After reset, `ready_o` is 0 and `result_o` is all zeros.
- R2: Bit numbering: DES bit 1 is `ct_i[63]` and bit 64 is `ct_i[0]`. The standard DES initial permutation is applied to the ciphertext. Its output bits 1..32 form L and its output bits 33..64 form R.
- R3: The value of `box_i` is b, from 0 to 7, and it selects S-box b+1. The six expansion bits for that box are the R bits 4b, 4b+1, ..., 4b+5, counted from 1 and wrapping at 32, so bit 0 wraps to bit 32. The first of these six bits is the most significant bit of the six-bit value.
- R4: The six bits are XORed with the guess. In the result x, the row is {x[5], x[0]} and the column is x[4:1]. The row and column address the standard DES S-box b+1.
- R5: The parameter TARGET_BIT picks one bit of the 4-bit S-box output. A value of 0 means the MSB, and 0 is the default. The target is the round-function bit 4b+1+TARGET_BIT. Its position i after the P permutation selects L bit i. The prediction is 1 when the two bits differ and 0 when they are equal.
- R6: Guesses are evaluated in ascending order, 0 to 63. Bit g of `result_o` holds the prediction for guess g.
- R7: A start pulse accepted at clock edge E gives a `ready_o` pulse exactly one cycle wide. The pulse is high after edge E+64 and low again after edge E+65.
- R8: A start pulse that arrives while a sweep is running has no effect. Both the ready timing and the result of the running sweep stay unchanged.
- R9: While idle and without a start pulse, `result_o` stays constant, whatever `ct_i` and `box_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a sweep when idle. Sampled together with `ct_i` and `box_i` |
| ct_i | input | 64 | Ciphertext. DES bit 1 is at the MSB |
| box_i | input | 3 | S-box under test, 0 to 7 for S-boxes 1 to 8 |
| ready_o | output | 1 | One-cycle pulse when all 64 predictions are stored |
| result_o | output | 64 | Bit g is the prediction for guess g |

## Verification
The embedded assertions check the sequencing rules on every cycle. These rules are: the guess counter steps up by one while busy, every sweep starts at guess 0, the last guess ends the sweep with a single ready pulse, and the result vector does not move while idle. The prediction values themselves, meaning the permutation, expansion, S-box and P-position mapping, can only be shown by the bench. It sweeps every S-box against several ciphertexts and compares all 64 bits with its own model built from the public tables. The bench alone also shows that a start pulse during a sweep leaves that sweep alone, and that input changes while idle leave the result alone.

// File: rtl/des_sel_pkg.sv
package des_sel_pkg;
  localparam int GUESS_W = 6;
  localparam int N_GUESS = 1 << GUESS_W;
  localparam int BLK_W   = 64;
  localparam int HALF_W  = BLK_W / 2;
  localparam int N_BOX   = 8;
  localparam int BOX_W   = $clog2(N_BOX);
  localparam int SOUT_W  = 4;

  // source bit (1-based) feeding output bit j of the initial permutation
  function automatic int ip_src(input int j);
    int r, c;
    r = (j - 1) / 8;
    c = (j - 1) % 8;
    return ((r < 4) ? (58 + 2 * r) : (57 + 2 * (r - 4))) - 8 * c;
  endfunction

  // output position of round-function bit v after P, indexed by v-1
  localparam int P_INV [HALF_W] = '{
    9, 17, 23, 31, 13, 28, 2, 18, 24, 16, 30, 6, 26, 20, 10, 1,
    8, 14, 25, 3, 4, 29, 11, 19, 32, 12, 22, 7, 5, 27, 15, 21};

  // one row per entry (box*4+row), 16 nibbles, column 0 in the top nibble
  localparam logic [63:0] SBOX_ROWS [N_BOX*4] = '{
    64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538, 64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D,
    64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5, 64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9,
    64'hA09E63F51DC7B428, 64'hD709346A285ECBF1, 64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C,
    64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9, 64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E,
    64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986, 64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453,
    64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38, 64'h9EF528C3704A1DB6, 64'h432C95FABE17608D,
    64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86, 64'h14BDC37EAF680592, 64'h6BD814A7950FE23C,
    64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92, 64'h7B419CE206ADF358, 64'h21E74A8DFC90356B};
endpackage

// File: rtl/des_sel_front.sv
module des_sel_front
  import des_sel_pkg::*;
#(
  parameter int TARGET_BIT = 0
) (
  input  logic [BLK_W-1:0]   ct_i,
  input  logic [BOX_W-1:0]   box_i,
  output logic [GUESS_W-1:0] e6_o,
  output logic               lbit_o
);
  logic [BLK_W-1:0] ip_v;  // DES bit j at ip_v[64-j]

  always_comb begin
    int b, rpos, lpos;
    b = int'(box_i);
    for (int j = 1; j <= BLK_W; j++) ip_v[BLK_W-j] = ct_i[BLK_W-ip_src(j)];
    for (int k = 0; k < GUESS_W; k++) begin
      rpos = ((4 * b + k + HALF_W - 1) % HALF_W) + 1;
      e6_o[GUESS_W-1-k] = ip_v[HALF_W-rpos];
    end
    lpos   = P_INV[SOUT_W * b + TARGET_BIT];
    lbit_o = ip_v[BLK_W-lpos];
  end
endmodule

// File: rtl/des_sel_sbox.sv
module des_sel_sbox
  import des_sel_pkg::*;
(
  input  logic [BOX_W-1:0]   box_i,
  input  logic [GUESS_W-1:0] x_i,
  output logic [SOUT_W-1:0]  s_o
);
  always_comb begin
    int row, col;
    logic [63:0] line;
    row  = int'({x_i[GUESS_W-1], x_i[0]});
    col  = int'(x_i[GUESS_W-2:1]);
    line = SBOX_ROWS[int'(box_i) * 4 + row];
    s_o  = line[63 - SOUT_W * col -: SOUT_W];
  end
endmodule

// File: rtl/des_sel_predictor.sv
module des_sel_predictor
  import des_sel_pkg::*;
#(
  parameter int TARGET_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [63:0]       ct_i,
  input  logic [2:0]        box_i,
  output logic              ready_o,
  output logic [63:0]       result_o
);
  localparam logic [GUESS_W-1:0] LAST_GUESS = GUESS_W'(N_GUESS - 1);

  logic [GUESS_W-1:0] e6_w, e6_q, guess_q;
  logic               lbit_w, lbit_q, busy_q, ready_q, pred_w;
  logic [BOX_W-1:0]   box_q;
  logic [SOUT_W-1:0]  sout_w;
  logic [N_GUESS-1:0] result_q;

  des_sel_front #(.TARGET_BIT(TARGET_BIT)) u_front (
    .ct_i  (ct_i),
    .box_i (box_i),
    .e6_o  (e6_w),
    .lbit_o(lbit_w)
  );

  des_sel_sbox u_sbox (
    .box_i(box_q),
    .x_i  (e6_q ^ guess_q),
    .s_o  (sout_w)
  );

  assign pred_w = sout_w[SOUT_W-1-TARGET_BIT] ^ lbit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      ready_q  <= 1'b0;
      guess_q  <= '0;
      e6_q     <= '0;
      lbit_q   <= 1'b0;
      box_q    <= '0;
      result_q <= '0;
    end else begin
      ready_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          guess_q <= '0;
          e6_q    <= e6_w;
          lbit_q  <= lbit_w;
          box_q   <= box_i;
        end
      end else begin
        result_q[guess_q] <= pred_w;
        if (guess_q == LAST_GUESS) begin
          busy_q  <= 1'b0;
          ready_q <= 1'b1;
        end else begin
          guess_q <= guess_q + 1'b1;
        end
      end
    end
  end

  assign ready_o  = ready_q;
  assign result_o = result_q;

  AST_GUESS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && guess_q != LAST_GUESS) |=> (busy_q && guess_q == $past(guess_q) + 1'b1)); // R6
  AST_SWEEP_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (guess_q == '0)); // R6
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && guess_q == LAST_GUESS) |=> (ready_o && !busy_q)); // R7
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R7
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && guess_q != LAST_GUESS) |=> (busy_q && $stable(e6_q) && $stable(box_q))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> $stable(result_o)); // R9
endmodule

// File: tb/des_sel_predictor_test.sv
module des_sel_predictor_test;
  localparam int TB = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ct = '0;
  logic [2:0]  box = '0;
  logic        ready;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  des_sel_predictor #(.TARGET_BIT(TB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ct_i(ct), .box_i(box),
    .ready_o(ready), .result_o(result));

  int ip_t [64] = '{
    58, 50, 42, 34, 26, 18, 10, 2, 60, 52, 44, 36, 28, 20, 12, 4,
    62, 54, 46, 38, 30, 22, 14, 6, 64, 56, 48, 40, 32, 24, 16, 8,
    57, 49, 41, 33, 25, 17, 9, 1, 59, 51, 43, 35, 27, 19, 11, 3,
    61, 53, 45, 37, 29, 21, 13, 5, 63, 55, 47, 39, 31, 23, 15, 7};
  int e_t [48] = '{
    32, 1, 2, 3, 4, 5, 4, 5, 6, 7, 8, 9, 8, 9, 10, 11, 12, 13,
    12, 13, 14, 15, 16, 17, 16, 17, 18, 19, 20, 21, 20, 21, 22, 23, 24, 25,
    24, 25, 26, 27, 28, 29, 28, 29, 30, 31, 32, 1};
  int p_t [32] = '{
    16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
    2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};
  logic [63:0] sb [32] = '{
    64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538, 64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D,
    64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5, 64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9,
    64'hA09E63F51DC7B428, 64'hD709346A285ECBF1, 64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C,
    64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9, 64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E,
    64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986, 64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453,
    64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38, 64'h9EF528C3704A1DB6, 64'h432C95FABE17608D,
    64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86, 64'h14BDC37EAF680592, 64'h6BD814A7950FE23C,
    64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92, 64'h7B419CE206ADF358, 64'h21E74A8DFC90356B};

  // permuted bit j (1-based); L = 1..32, R = 33..64 (R2)
  function automatic logic ipb(input logic [63:0] c, input int j);
    return c[64 - ip_t[j-1]];
  endfunction

  function automatic logic [63:0] model(input logic [63:0] c, input int b);
    logic [63:0] v;
    for (int g = 0; g < 64; g++) begin
      logic [5:0] x;
      logic [3:0] s;
      int row, col, q, pos;
      for (int k = 0; k < 6; k++) x[5-k] = ipb(c, 32 + e_t[6*b + k]);  // R3
      x   = x ^ 6'(g);                                                   // R4
      row = 2 * int'(x[5]) + int'(x[0]);
      col = int'(x[4:1]);
      s   = sb[4*b + row][63 - 4*col -: 4];
      q   = 4*b + 1 + TB;                                                // R5
      pos = 0;
      for (int i = 0; i < 32; i++) if (p_t[i] == q) pos = i + 1;
      v[g] = s[3-TB] ^ ipb(c, pos);                                      // R6: bit g
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start at a negedge, optional busy start at cycle 10, check ready timing and result
  task automatic sweep(input logic [63:0] c, input int b, input bit poke);
    logic [63:0] exp;
    bit timing_ok;
    exp = model(c, b);
    ct = c; box = 3'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    timing_ok = 1'b1;
    for (int n = 1; n <= 64; n++) begin
      if (ready) timing_ok = 1'b0;
      if (poke && n == 10) begin
        ct = ~c; box = 3'(b + 1); start = 1'b1;  // R8: must be ignored
      end
      @(negedge clk);
      start = 1'b0;
    end
    if (!ready) timing_ok = 1'b0;
    @(negedge clk);
    if (ready) timing_ok = 1'b0;
    chk(timing_ok, "R7 ready pulse", 64'(ready), 64'h0);
    for (int g = 0; g < 64; g++)
      chk(result[g] == exp[g], poke ? "R8 busy start" : "R2 R3 R4 R5 R6 prediction",
          64'(result[g]), 64'(exp[g]));
  endtask

  initial begin
    logic [63:0] vecs [6];
    logic [63:0] hold;
    vecs[0] = 64'h0; vecs[1] = '1; vecs[2] = 64'h0123456789ABCDEF;
    vecs[3] = 64'h85E813540F0AB405; vecs[4] = 64'h8000000000000001; vecs[5] = 64'hA5A55A5A3C3CC3C3;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0 && result == '0, "R1 reset", result, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 6; v++)
      for (int b = 0; b < 8; b++) sweep(vecs[v], b, 1'b0);
    sweep(64'hFEDCBA9876543210, 3, 1'b1);
    sweep(64'h13579BDF02468ACE, 7, 1'b1);
    hold = result;
    for (int n = 0; n < 8; n++) begin
      ct = {ct[62:0], ~ct[63]} ^ 64'h9E3779B97F4A7C15; box = 3'(n);
      @(negedge clk);
    end
    chk(result == hold, "R9 idle hold", result, hold);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule